// File: doc/BRIEF.md
# Drift-Trimmed Nanosecond Time Counter

This block keeps a 64-bit nanosecond time value for a packet timestamping clock. On every clock it advances by a fixed nominal amount, 8 ns by default. A drift corrector trims the rate by adding or removing a few extra nanoseconds whenever a programmable interval expires. Software computes the correction from a frequency error, and the block only applies the packed result.

Software controls the counter through a plain strobe interface with a 3-bit register address. It can pause and resume the counter. While the counter is paused, software can load a new 64-bit value in two 32-bit halves. A new drift configuration is written under a reset handshake. The live time can be read back as two 32-bit words that are never torn by a carry. The full time value is also driven on a port for the timestamp capture logic.

Top module: `tsc_top`

## Requirements
- R1: After reset the time value is 0 and the counter is running. The drift-reset bit, the drift configuration and the pause flag all read as 0.
- R2: While running, the time value grows by exactly 8 ns on every clock cycle that carries no correction.
- R3: The drift configuration word (address 3) holds the interval in bits 27:0, the step in nanoseconds in bits 30:28 and the direction in bit 31. On a correction cycle the time value grows by 8 plus the step when the direction is 1, and by 8 minus the step when it is 0.
- R4: Corrections are spaced interval×16+8 ns apart, which is 2×interval+1 running cycles. After the drift-reset bit is cleared, the first correction comes 2×interval+1 running cycles after the counter runs again.
- R5: A write to the drift configuration is accepted only while the drift-reset bit is 1. At any other time the write is ignored, and a read of address 3 returns the old word.
- R6: The drift-reset bit sits at bit 0 of address 4 and reads back its current value. While it is 1, no correction is applied and the interval countdown is held at its reload value.
- R7: At control address 0, a write of 2 pauses the counter and a write of 4 resumes it. Any other value has no effect. A read of address 0 returns the pause flag in bit 0. While paused, the time value holds.
- R8: While paused, writes to address 1 replace bits 31:0 of the time value and writes to address 2 replace bits 63:32. While running, both writes are ignored.
- R9: Reads have one cycle of latency. A read of address 5 returns time bits 31:0 and also captures bits 63:32 at that same instant. A later read of address 6 returns the captured upper half, so a carry that occurs between the two reads cannot tear the pair.
- R10: A step of 0 applies no correction. The configuration words 0x0FFFFFFF and 0 therefore both leave the counter at the nominal rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en, held until the next read |
| time_o | output | 64 | Live time value in nanoseconds |

## Verification
A wrong interval countdown or a wrong reload value does not show at once. The first symptom is a cycle whose increment differs from 8 ns, and it appears at the first correction that falls early or late, so a window of at least 2×interval+1 cycles must be observed. A wrong direction or step value shows on the very first correction cycle, because the increment on `time_o` has the wrong size. Faults in the pause, load or configuration gating show within one cycle of the offending write, either on `time_o` or on the next readback. A snapshot fault only shows when a carry lands between a low read and a high read, which is why that case is driven on purpose.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam int CFG_W  = 32;
   localparam int IVL_W  = 28;
   localparam int STEP_W = 3;

   // register addresses on the strobe interface
   typedef enum logic [2:0] {
      TSC_CTRL    = 3'd0,
      TSC_LOAD_LO = 3'd1,
      TSC_LOAD_HI = 3'd2,
      TSC_DCFG    = 3'd3,
      TSC_DRST    = 3'd4,
      TSC_TIME_LO = 3'd5,
      TSC_TIME_HI = 3'd6
   } tsc_addr_e;

   // packed drift triplet: direction on top, step, then interval in 16 ns quanta
   typedef struct packed {
      logic              add;
      logic [STEP_W-1:0] step;
      logic [IVL_W-1:0]  ivl;
   } drift_cfg_t;

   localparam logic [CFG_W-1:0] CMD_PAUSE  = 32'd2;
   localparam logic [CFG_W-1:0] CMD_RESUME = 32'd4;
endpackage

// File: rtl/tsc_drift_timer.sv
module tsc_drift_timer #(
   parameter int IVL_W      = 28,
   parameter int NOM_NS     = 8,
   parameter int QUANTUM_NS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic [IVL_W-1:0] ivl,
   output logic             tick
);
   localparam int RATIO = QUANTUM_NS / NOM_NS;
   localparam int SHIFT = $clog2(RATIO);
   localparam int CNT_W = IVL_W + $clog2(RATIO + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   // reload = interval quanta expressed in clock cycles
   generate
      if ((1 << SHIFT) == RATIO) begin : g_shift
         assign reload = CNT_W'(ivl) << SHIFT;
      end else begin : g_mult
         assign reload = CNT_W'(ivl) * CNT_W'(RATIO);
      end
   endgenerate

   assign tick = run && !hold && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (hold) begin
         cnt_q <= reload;
      end else if (run) begin
         if (cnt_q == '0) cnt_q <= reload;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/tsc_accum.sv
module tsc_accum #(
   parameter int TIME_W = 64,
   parameter int DATA_W = 32,
   parameter int STEP_W = 3,
   parameter int NOM_NS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic              add,
   input  logic [STEP_W-1:0] step,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [DATA_W-1:0] ld_data,
   output logic [TIME_W-1:0] time_q
);
   localparam int HI_W = TIME_W - DATA_W;

   logic [TIME_W-1:0] inc;

   always_comb begin
      inc = TIME_W'(NOM_NS);
      if (tick) begin
         if (add) inc = inc + TIME_W'(step);
         else     inc = inc - TIME_W'(step);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_q <= '0;
      end else if (ld_lo) begin
         time_q[DATA_W-1:0] <= ld_data;
      end else if (ld_hi) begin
         time_q[TIME_W-1:DATA_W] <= ld_data[HI_W-1:0];
      end else if (run) begin
         time_q <= time_q + inc;
      end
   end
endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
   import tsc_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [2:0]        rd_addr,
   input  logic [TIME_W-1:0] time_q,
   output logic              paused_q,
   output logic              drift_rst_q,
   output drift_cfg_t        cfg_q,
   output logic              ld_lo,
   output logic              ld_hi,
   output logic [DATA_W-1:0] rd_data
);
   localparam int HI_W = TIME_W - DATA_W;

   logic [HI_W-1:0]   hi_snap_q;
   logic [DATA_W-1:0] rd_mux;

   assign ld_lo = wr_en && (wr_addr == TSC_LOAD_LO) && paused_q;
   assign ld_hi = wr_en && (wr_addr == TSC_LOAD_HI) && paused_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paused_q    <= 1'b0;
         drift_rst_q <= 1'b0;
         cfg_q       <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            TSC_CTRL: begin
               if (wr_data == CMD_PAUSE)       paused_q <= 1'b1;
               else if (wr_data == CMD_RESUME) paused_q <= 1'b0;
            end
            TSC_DCFG: if (drift_rst_q) cfg_q <= drift_cfg_t'(wr_data);
            TSC_DRST: drift_rst_q <= wr_data[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         TSC_CTRL:    rd_mux = DATA_W'(paused_q);
         TSC_DCFG:    rd_mux = DATA_W'(cfg_q);
         TSC_DRST:    rd_mux = DATA_W'(drift_rst_q);
         TSC_TIME_LO: rd_mux = time_q[DATA_W-1:0];
         TSC_TIME_HI: rd_mux = DATA_W'(hi_snap_q);
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '0;
         hi_snap_q <= '0;
      end else if (rd_en) begin
         rd_data <= rd_mux;
         if (rd_addr == TSC_TIME_LO) hi_snap_q <= time_q[TIME_W-1:DATA_W];
      end
   end
endmodule

// File: rtl/tsc_top.sv
module tsc_top
   import tsc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int TIME_W     = 64,
   parameter int NOM_NS     = 8,
   parameter int QUANTUM_NS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [TIME_W-1:0] time_o
);
   localparam int MAX_STEP = (1 << STEP_W) - 1;

   generate
      if (DATA_W != 1 + STEP_W + IVL_W) begin : g_bad_cfg_w
         $error("config word width must equal direction+step+interval");
      end
      if (TIME_W <= DATA_W || TIME_W > 2 * DATA_W) begin : g_bad_time_w
         $error("time width must fit in two data words");
      end
      if (QUANTUM_NS % NOM_NS != 0) begin : g_bad_quantum
         $error("quantum must be a multiple of the nominal increment");
      end
      if (NOM_NS <= MAX_STEP) begin : g_bad_nom
         $error("nominal increment must exceed the largest step");
      end
   endgenerate

   logic       paused_q;
   logic       drift_rst_q;
   drift_cfg_t cfg_q;
   logic       ld_lo;
   logic       ld_hi;
   logic       tick;
   logic [TIME_W-1:0] time_q;

   tsc_regs #(.TIME_W(TIME_W), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .time_q(time_q),
      .paused_q(paused_q), .drift_rst_q(drift_rst_q), .cfg_q(cfg_q),
      .ld_lo(ld_lo), .ld_hi(ld_hi), .rd_data(rd_data)
   );

   tsc_drift_timer #(.IVL_W(IVL_W), .NOM_NS(NOM_NS), .QUANTUM_NS(QUANTUM_NS)) timer_i (
      .clk(clk), .rst_n(rst_n),
      .run(!paused_q), .hold(drift_rst_q), .ivl(cfg_q.ivl), .tick(tick)
   );

   tsc_accum #(.TIME_W(TIME_W), .DATA_W(DATA_W), .STEP_W(STEP_W), .NOM_NS(NOM_NS)) accum_i (
      .clk(clk), .rst_n(rst_n),
      .run(!paused_q), .tick(tick), .add(cfg_q.add), .step(cfg_q.step),
      .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(wr_data), .time_q(time_q)
   );

   assign time_o = time_q;
endmodule

// File: rtl/tsc_top_chk.sv
module tsc_top_chk
   import tsc_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int NOM_NS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic              paused_q,
   input logic              drift_rst_q,
   input drift_cfg_t        cfg_q,
   input logic              tick,
   input logic [TIME_W-1:0] time_q
);
   localparam int MAX_STEP = (1 << STEP_W) - 1;

   // R2
   nominal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!paused_q && !tick) |=> (time_q == $past(time_q) + TIME_W'(NOM_NS)));

   // R3
   corr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!paused_q && tick) |=>
         ((time_q - $past(time_q)) <= TIME_W'(NOM_NS + MAX_STEP)) &&
         ((time_q - $past(time_q)) >= TIME_W'(NOM_NS - MAX_STEP)));

   // R6
   no_corr_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drift_rst_q |-> !tick);

   // R5
   cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drift_rst_q |=> $stable(cfg_q));

   // R7
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (paused_q && !(wr_en && (wr_addr == TSC_LOAD_LO || wr_addr == TSC_LOAD_HI)))
         |=> $stable(time_q));
endmodule

bind tsc_top tsc_top_chk #(.TIME_W(TIME_W), .NOM_NS(NOM_NS)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .paused_q(paused_q), .drift_rst_q(drift_rst_q), .cfg_q(cfg_q),
   .tick(tick), .time_q(time_q)
);

// File: tb/tsc_top_tb_top.sv
module tsc_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [63:0] time_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tsc_top dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .time_o(time_o)
   );

   // reference model built from the requirements
   logic [63:0] m_time;
   logic        m_paused, m_drst;
   logic [31:0] m_cfg, m_rd, m_snap;
   logic [29:0] m_cnt;

   function automatic logic [29:0] f_reload(logic [31:0] c);
      return {c[27:0], 1'b0};
   endfunction

   function automatic logic [63:0] f_inc(logic corr, logic [31:0] c);
      logic [63:0] v = 64'd8;
      if (corr) v = c[31] ? v + 64'(c[30:28]) : v - 64'(c[30:28]);
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_time <= '0; m_paused <= 0; m_drst <= 0; m_cfg <= '0;
         m_rd <= '0; m_snap <= '0; m_cnt <= '0;
      end else begin
         logic corr;
         corr = !m_paused && !m_drst && (m_cnt == '0);
         if (!m_paused) m_time <= m_time + f_inc(corr, m_cfg);
         if (m_drst) m_cnt <= f_reload(m_cfg);
         else if (!m_paused) m_cnt <= corr ? f_reload(m_cfg) : m_cnt - 1'b1;
         if (wr_en) begin
            case (wr_addr)
               3'd0: if (wr_data == 32'd2) m_paused <= 1; else if (wr_data == 32'd4) m_paused <= 0;
               3'd1: if (m_paused) m_time[31:0] <= wr_data;
               3'd2: if (m_paused) m_time[63:32] <= wr_data;
               3'd3: if (m_drst) m_cfg <= wr_data;
               3'd4: m_drst <= wr_data[0];
               default: ;
            endcase
         end
         if (rd_en) begin
            case (rd_addr)
               3'd0: m_rd <= {31'b0, m_paused};
               3'd3: m_rd <= m_cfg;
               3'd4: m_rd <= {31'b0, m_drst};
               3'd5: begin m_rd <= m_time[31:0]; m_snap <= m_time[63:32]; end
               3'd6: m_rd <= m_snap;
               default: m_rd <= '0;
            endcase
         end
      end
   end

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // continuous comparison against the model (R2 time, R9 read data)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 time_o vs model", time_o, m_time);
         check("R9 rd_data vs model", 64'(rd_data), 64'(m_rd));
      end
   end

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] v);
      @(negedge clk); rd_en = 1; rd_addr = a;
      @(negedge clk); rd_en = 0; v = rd_data;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [63:0] a;
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      check("R1 time in reset", time_o, 64'd0);
      rst_n = 1;
      rd(3'd3, v); check("R1 cfg reset", 64'(v), 64'd0);
      rd(3'd4, v); check("R1 drift reset bit", 64'(v), 64'd0);
      rd(3'd0, v); check("R1 pause flag", 64'(v), 64'd0);

      // R2 nominal rate
      a = time_o; repeat (10) @(negedge clk);
      check("R2 ten nominal cycles", time_o, a + 64'd80);

      // R7 pause, R8 load while paused
      wr(3'd0, 32'd2);
      a = time_o; repeat (5) @(negedge clk);
      check("R7 paused holds", time_o, a);
      wr(3'd1, 32'h1234_5678); wr(3'd2, 32'h0000_000A);
      check("R8 paused load", time_o, 64'h0000_000A_1234_5678);

      // R5 config ignored while drift reset is 0
      wr(3'd3, 32'hD000_0003);
      rd(3'd3, v); check("R5 cfg write ignored", 64'(v), 64'd0);
      wr(3'd4, 32'd1);
      rd(3'd4, v); check("R6 drift reset readback", 64'(v), 64'd1);
      wr(3'd3, 32'hD000_0003);
      rd(3'd3, v); check("R3 cfg accepted", 64'(v), 64'hD000_0003);

      // R4 spacing: interval 3 -> every 7 cycles, +5 ns
      wr(3'd4, 32'd0);
      wr(3'd0, 32'd4);
      check("R7 resume edge no advance", time_o, 64'h0000_000A_1234_5678);
      repeat (14) @(negedge clk);
      check("R4 add two corrections", time_o, 64'h0000_000A_1234_5678 + 64'd122);

      // R3 subtract direction
      wr(3'd0, 32'd2); wr(3'd4, 32'd1); wr(3'd3, 32'h5000_0003); wr(3'd4, 32'd0);
      wr(3'd1, 32'd0); wr(3'd2, 32'd0); wr(3'd0, 32'd4);
      repeat (14) @(negedge clk);
      check("R3 subtract two corrections", time_o, 64'd102);

      // R8 load ignored while running (corrections off)
      wr(3'd4, 32'd1);
      a = time_o; wr(3'd1, 32'h0000_FFFF);
      check("R8 load ignored running", time_o, a + 64'd16);

      // R4 interval 0, step 7 -> every cycle +15
      wr(3'd3, 32'hF000_0000); wr(3'd4, 32'd0);
      a = time_o; repeat (4) @(negedge clk);
      check("R4 interval zero", time_o, a + 64'd60);

      // R10 disabled configurations
      wr(3'd4, 32'd1); wr(3'd3, 32'h0FFF_FFFF); wr(3'd4, 32'd0);
      a = time_o; repeat (20) @(negedge clk);
      check("R10 max interval step zero", time_o, a + 64'd160);
      wr(3'd4, 32'd1); wr(3'd3, 32'h0000_0000); wr(3'd4, 32'd0);
      a = time_o; repeat (20) @(negedge clk);
      check("R10 zero config", time_o, a + 64'd160);

      // R9 untorn read across a carry
      wr(3'd0, 32'd2); wr(3'd4, 32'd1);
      wr(3'd1, 32'hFFFF_FFF0); wr(3'd2, 32'd1); wr(3'd0, 32'd4);
      rd(3'd5, v); check("R9 low word", 64'(v), 64'hFFFF_FFF8);
      rd(3'd6, v); check("R9 snapshot high", 64'(v), 64'd1);
      check("R9 live high moved", 64'(time_o[63:32]), 64'd2);

      // R7 other control values ignored
      wr(3'd0, 32'd3);
      rd(3'd0, v); check("R7 other value ignored", 64'(v), 64'd0);

      // random phase, checked against the model every cycle
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         wr_en = 0; rd_en = 0;
         if ($urandom_range(0, 3) == 0) begin
            wr_en = 1;
            wr_addr = 3'($urandom_range(0, 7));
            case ($urandom_range(0, 3))
               0: wr_data = 32'd2;
               1: wr_data = 32'd4;
               2: wr_data = {$urandom_range(0, 15) > 7 ? 1'b1 : 1'b0, 3'($urandom_range(0, 7)), 24'd0, 4'($urandom_range(0, 15))};
               default: wr_data = $urandom;
            endcase
            if (wr_addr == 3'd0 && $urandom_range(0, 3) != 0) wr_data = 32'd4;
         end
         if ($urandom_range(0, 2) == 0) begin
            rd_en = 1;
            rd_addr = 3'($urandom_range(0, 7));
         end
      end
      @(negedge clk); wr_en = 0; rd_en = 0;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule